// File: doc/BRIEF.md
# SRAM Sleep Mode Sequencer

This block controls when a synchronous SRAM core drops into its low-power sleep state and when it comes back. A request input, which may change at any time and is high while sleep is wanted, first passes through a flop synchronizer. A four-state machine then counts a fixed entry delay and a fixed exit delay. From the state it derives three controls: a gate that lets commands into the core, a force that turns the data outputs to high-impedance, and a power-down flag for the array. The array and its contents sit outside this block, and the sequencer never clears them.

Each cycle, the surrounding command logic shows whether a command is presented (`cmd_sel`) and whether it is a write (`cmd_write`). The sequencer forwards or blocks that command. While the core wakes up, only reads and deselects may pass. A write in that window is dropped and reported. The block also reports when sleep is being entered while the core still holds a write that has not finished.

States: AWAKE (normal use), ENTERING (entry delay, inputs still accepted), ASLEEP (inputs ignored, outputs high-impedance, array powered down) and WAKING (exit delay, reads only). Transitions, each taken on a rising clock edge: AWAKE→ENTERING when the synchronized request is high. ENTERING→ASLEEP after ENTRY_CYC cycles. ASLEEP→WAKING when the synchronized request is low. WAKING→AWAKE after EXIT_CYC cycles. ENTERING and WAKING always run to completion.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset the block is AWAKE: accept_en=1, dq_hiz=0, core_pd=0, wake_wr_viol=0, wr_lost_err=0.
- R2: With default parameters (2 sync stages, ENTRY_CYC=2), core_pd goes high on the 5th rising edge after sleep_req rises. Up to and including the 4th edge, accept_en stays 1.
- R3: While core_pd=1, accept_en=0 and dq_hiz=1, and cmd_go, wr_go and wake_wr_viol are 0 whatever cmd_sel and cmd_write are.
- R4: With default parameters, core_pd falls on the 3rd rising edge after sleep_req falls, and this starts WAKING. Full writes are allowed again from the 5th edge.
- R5: In WAKING a read (cmd_sel=1, cmd_write=0) gives cmd_go=1. A write (cmd_sel=1, cmd_write=1) gives cmd_go=0, wr_go=0 and wake_wr_viol=1.
- R6: wr_lost_err is 1 exactly in ENTERING cycles where wr_pending=1, and 0 in every other case.
- R7: In AWAKE, cmd_go equals cmd_sel and wr_go equals cmd_sel AND cmd_write.
- R8: If sleep_req falls during ENTERING, entry still reaches ASLEEP. The block then wakes through WAKING without skipping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| cmd_sel | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | Presented command is a write (0 = read) |
| wr_pending | input | 1 | Core still holds an unfinished write |
| accept_en | output | 1 | Synchronous inputs are sampled |
| dq_hiz | output | 1 | Force data outputs to high-impedance |
| core_pd | output | 1 | Array power-down flag |
| cmd_go | output | 1 | Command forwarded to the core |
| wr_go | output | 1 | Write forwarded to the core |
| wake_wr_viol | output | 1 | Write attempted during wake-up, dropped |
| wr_lost_err | output | 1 | Sleep being entered with a write pending |

## Verification
The assertions check the following on every cycle. While powered down, nothing is forwarded and the outputs are held at high-impedance. A flagged wake-up write never reaches the core. Power-down begins only from ENTERING and ends only into WAKING. The lost-write flag never rises while asleep or without a pending write. The exact edge counts for entry and exit are shown only by the bench's scenarios, by counting edges from a request change. So are the completion of entry after the request drops and the read-only behaviour inside the wake window.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ENTERING = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_WAKING   = 2'd3
    } slp_state_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= d_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    output slp_state_t st
);
    localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

    slp_state_t       nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_AWAKE:    if (req_s)              nxt = ST_ENTERING;
            ST_ENTERING: if (cnt == ENTRY_LAST)  nxt = ST_ASLEEP;
            ST_ASLEEP:   if (!req_s)             nxt = ST_WAKING;
            ST_WAKING:   if (cnt == EXIT_LAST)   nxt = ST_AWAKE;
            default:                             nxt = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_AWAKE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt != st)
                cnt <= '0;
            else if (st == ST_ENTERING || st == ST_WAKING)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slp_gate.sv
module slp_gate
    import sleep_pkg::*;
(
    input  slp_state_t st,
    input  logic       cmd_sel,
    input  logic       cmd_write,
    input  logic       wr_pending,
    output logic       accept_en,
    output logic       dq_hiz,
    output logic       core_pd,
    output logic       cmd_go,
    output logic       wr_go,
    output logic       wake_wr_viol,
    output logic       wr_lost_err
);
    always_comb begin
        accept_en    = 1'b1;
        dq_hiz       = 1'b0;
        core_pd      = 1'b0;
        cmd_go       = 1'b0;
        wr_go        = 1'b0;
        wake_wr_viol = 1'b0;
        wr_lost_err  = 1'b0;
        unique case (st)
            ST_AWAKE: begin
                cmd_go = cmd_sel;
                wr_go  = cmd_sel & cmd_write;
            end
            ST_ENTERING: begin
                cmd_go      = cmd_sel;
                wr_go       = cmd_sel & cmd_write;
                wr_lost_err = wr_pending;
            end
            ST_ASLEEP: begin
                accept_en = 1'b0;
                dq_hiz    = 1'b1;
                core_pd   = 1'b1;
            end
            ST_WAKING: begin
                cmd_go       = cmd_sel & ~cmd_write;
                wake_wr_viol = cmd_sel & cmd_write;
            end
            default: accept_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic cmd_sel,
    input  logic cmd_write,
    input  logic wr_pending,
    output logic accept_en,
    output logic dq_hiz,
    output logic core_pd,
    output logic cmd_go,
    output logic wr_go,
    output logic wake_wr_viol,
    output logic wr_lost_err
);
    logic       req_s;
    slp_state_t st;

    slp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req),
        .q_sync  (req_s)
    );

    slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) i_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req_s (req_s),
        .st    (st)
    );

    slp_gate i_gate (
        .st           (st),
        .cmd_sel      (cmd_sel),
        .cmd_write    (cmd_write),
        .wr_pending   (wr_pending),
        .accept_en    (accept_en),
        .dq_hiz       (dq_hiz),
        .core_pd      (core_pd),
        .cmd_go       (cmd_go),
        .wr_go        (wr_go),
        .wake_wr_viol (wake_wr_viol),
        .wr_lost_err  (wr_lost_err)
    );
endmodule

// File: rtl/sram_sleep_chk.sv
module sram_sleep_chk
    import sleep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input slp_state_t st,
    input logic       wr_pending,
    input logic       accept_en,
    input logic       dq_hiz,
    input logic       core_pd,
    input logic       cmd_go,
    input logic       wr_go,
    input logic       wake_wr_viol,
    input logic       wr_lost_err
);
    AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        core_pd |-> (!accept_en && dq_hiz && !cmd_go && !wr_go)); // R3
    AST_WAKE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_wr_viol |-> (!wr_go && !cmd_go)); // R5
    AST_PD_FROM_ENTERING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_pd) |-> ($past(st) == ST_ENTERING)); // R2
    AST_PD_INTO_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_pd) |-> (st == ST_WAKING)); // R4
    AST_LOST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lost_err |-> (wr_pending && !core_pd)); // R6
    AST_WRITE_IS_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (cmd_go && accept_en)); // R7
endmodule

bind sram_sleep_ctrl sram_sleep_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .wr_pending   (wr_pending),
    .accept_en    (accept_en),
    .dq_hiz       (dq_hiz),
    .core_pd      (core_pd),
    .cmd_go       (cmd_go),
    .wr_go        (wr_go),
    .wake_wr_viol (wake_wr_viol),
    .wr_lost_err  (wr_lost_err)
);

// File: tb/test_sram_sleep_ctrl.sv
`timescale 1ns/1ps
module test_sram_sleep_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic cmd_sel = 1'b0;
    logic cmd_write = 1'b0;
    logic wr_pending = 1'b0;
    logic accept_en, dq_hiz, core_pd, cmd_go, wr_go, wake_wr_viol, wr_lost_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_sleep_ctrl i_sram_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cmd_sel(cmd_sel), .cmd_write(cmd_write), .wr_pending(wr_pending),
        .accept_en(accept_en), .dq_hiz(dq_hiz), .core_pd(core_pd),
        .cmd_go(cmd_go), .wr_go(wr_go), .wake_wr_viol(wake_wr_viol),
        .wr_lost_err(wr_lost_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic s, input logic w);
        cmd_sel = s; cmd_write = w; #1;
    endtask

    task automatic t_reset;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        chk("R1 accept_en", accept_en, 1'b1);
        chk("R1 dq_hiz", dq_hiz, 1'b0);
        chk("R1 core_pd", core_pd, 1'b0);
        chk("R1 wake_wr_viol", wake_wr_viol, 1'b0);
        chk("R1 wr_lost_err", wr_lost_err, 1'b0);
    endtask

    task automatic t_awake_cmds;
        drive(1'b1, 1'b0);
        chk("R7 read cmd_go", cmd_go, 1'b1);
        chk("R7 read wr_go", wr_go, 1'b0);
        drive(1'b1, 1'b1);
        chk("R7 write cmd_go", cmd_go, 1'b1);
        chk("R7 write wr_go", wr_go, 1'b1);
        drive(1'b0, 1'b1);
        chk("R7 idle cmd_go", cmd_go, 1'b0);
        chk("R7 idle wr_go", wr_go, 1'b0);
    endtask

    task automatic t_enter;
        sleep_req = 1'b1;
        edges(3);
        chk("R2 entering accept_en", accept_en, 1'b1);
        chk("R2 entering core_pd", core_pd, 1'b0);
        edges(1);
        chk("R2 edge4 accept_en", accept_en, 1'b1);
        chk("R2 edge4 core_pd", core_pd, 1'b0);
        edges(1);
        chk("R2 edge5 core_pd", core_pd, 1'b1);
    endtask

    task automatic t_asleep_ignore;
        chk("R3 accept_en", accept_en, 1'b0);
        chk("R3 dq_hiz", dq_hiz, 1'b1);
        drive(1'b1, 1'b1);
        chk("R3 write cmd_go", cmd_go, 1'b0);
        chk("R3 write wr_go", wr_go, 1'b0);
        chk("R3 write viol", wake_wr_viol, 1'b0);
        drive(1'b1, 1'b0);
        chk("R3 read cmd_go", cmd_go, 1'b0);
        drive(1'b0, 1'b0);
        edges(4);
        chk("R3 held core_pd", core_pd, 1'b1);
    endtask

    task automatic t_wake;
        sleep_req = 1'b0;
        edges(2);
        chk("R4 edge2 core_pd", core_pd, 1'b1);
        edges(1);
        chk("R4 edge3 core_pd", core_pd, 1'b0);
        chk("R4 waking accept_en", accept_en, 1'b1);
        chk("R4 waking dq_hiz", dq_hiz, 1'b0);
        drive(1'b1, 1'b1);
        chk("R5 write viol", wake_wr_viol, 1'b1);
        chk("R5 write wr_go", wr_go, 1'b0);
        chk("R5 write cmd_go", cmd_go, 1'b0);
        drive(1'b1, 1'b0);
        chk("R5 read cmd_go", cmd_go, 1'b1);
        chk("R5 read viol", wake_wr_viol, 1'b0);
        drive(1'b1, 1'b1);
        edges(1);
        chk("R4 edge4 write blocked", wr_go, 1'b0);
        edges(1);
        chk("R4 edge5 write allowed", wr_go, 1'b1);
        chk("R4 edge5 viol clear", wake_wr_viol, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic t_pending_err;
        wr_pending = 1'b1;
        #1;
        chk("R6 awake no err", wr_lost_err, 1'b0);
        sleep_req = 1'b1;
        edges(2);
        chk("R6 still awake no err", wr_lost_err, 1'b0);
        edges(1);
        chk("R6 entering err", wr_lost_err, 1'b1);
        wr_pending = 1'b0; #1;
        chk("R6 entering no pending", wr_lost_err, 1'b0);
        wr_pending = 1'b1;
        edges(2);
        chk("R6 asleep no err", wr_lost_err, 1'b0);
        wr_pending = 1'b0;
        sleep_req = 1'b0;
        edges(5);
        chk("R6 back awake", core_pd, 1'b0);
    endtask

    task automatic t_drop_during_entry;
        sleep_req = 1'b1;
        edges(3);
        chk("R8 in entering", core_pd, 1'b0);
        sleep_req = 1'b0;
        edges(2);
        chk("R8 entry completes", core_pd, 1'b1);
        edges(1);
        chk("R8 waking core_pd", core_pd, 1'b0);
        drive(1'b1, 1'b1);
        chk("R8 waking blocks write", wake_wr_viol, 1'b1);
        edges(2);
        chk("R8 awake write", wr_go, 1'b1);
        drive(1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_awake_cmds();
        t_enter();
        t_asleep_ignore();
        t_wake();
        t_pending_err();
        t_drop_during_entry();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule